// File: doc/BRIEF.md
# Programmable Logic Output Macrocell Bank

This block is a row of output cells for a sum-of-products programmable logic device. Each cell receives a sum term that the logic array has already computed, plus a product term that enables its three-state pin driver. Two static configuration bits per cell pick one of four output modes: the cell either stores the sum term in a flip-flop or passes it straight through, and the pin level is either the true or the inverted value. Every cell returns a feedback bit to the array.

All cells share two array terms. The first is a synchronous set that loads HIGH into every register at the next rising clock edge. The second is an asynchronous clear that forces every register LOW at once and holds it there. Both terms reach registered cells only. A pass-through cell with its driver enable held off reads the external pin level back into the array, so it serves as a dedicated input.

The pin itself is modelled by three signals: the data the cell would drive, the drive enable, and the level read back from the pin.

Top module: `macro_cell_bank`

## Requirements
- R1: With cfgComb[i]=0 (registered), the cell's flip-flop captures sumTerm[i] on every rising clock edge when neither shared term is active, and the pin data reflects the stored bit.
- R2: With cfgComb[i]=1 (pass-through), the pin data follows sumTerm[i] in the same cycle with no clock edge needed.
- R3: With cfgActiveHigh[i]=1 the pin data equals the selected value; with cfgActiveHigh[i]=0 it is the inverse. This applies in both modes, and the stored register bit does not depend on it.
- R4: padOe[i] equals enableTerm[i]. While padOe[i] is 0, padOut[i] is driven 0.
- R5: In registered mode feedback[i] is the stored register bit, uninverted. In pass-through mode feedback[i] is padIn[i].
- R6: When syncSet is 1 at a rising clock edge and asyncClear is 0, every register loads 1.
- R7: When asyncClear goes to 1, every register goes to 0 at once, even in the middle of a cycle. It stays 0 for as long as asyncClear is held, and it takes priority over syncSet.
- R8: syncSet and asyncClear have no effect on the outputs of cells with cfgComb[i]=1.
- R9: A pass-through cell with enableTerm[i]=0 drives nothing, and its feedback[i] equals the external level on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all cell registers |
| asyncClear | input | 1 | Shared asynchronous clear term, active high |
| syncSet | input | 1 | Shared synchronous set term, active high |
| sumTerm | input | NUM_CELLS | Sum term from the array, one bit per cell |
| enableTerm | input | NUM_CELLS | Product term that enables the pin driver, one per cell |
| cfgComb | input | NUM_CELLS | Mode bit per cell: 0 registered, 1 pass-through |
| cfgActiveHigh | input | NUM_CELLS | Polarity bit per cell: 1 true, 0 inverted |
| padIn | input | NUM_CELLS | Level read back from each pin |
| padOut | output | NUM_CELLS | Data each cell would drive onto its pin |
| padOe | output | NUM_CELLS | Pin driver enable per cell |
| feedback | output | NUM_CELLS | Feedback bit returned to the array per cell |

## Verification
A fixed mixed configuration sets cells in all four mode and polarity combinations side by side. This separates registered from pass-through timing: a pass-through cell changes right after its input changes, while a registered cell waits for the edge. It also separates true from inverted pins, since the feedback stays uninverted while the pin flips. External pin levels are chosen to differ from the driven data. Any feedback taken from the wrong source, on a pass-through input-only cell or on a registered cell, therefore shows up as a mismatch.

Directed cases cover the following:
- set alone at an edge;
- a clear raised in the middle of a cycle, checked before the next edge;
- a clear held with set across an edge, which exposes a wrong priority.

Seeded random patterns then mix all terms and modes.

// File: rtl/olmc_pkg.sv
`timescale 1ns/1ps
package olmc_pkg;
  // Strobes from a cell's control decode to its datapath
  typedef struct packed {
    logic useReg;     // select register rather than the pass-through sum
    logic invertOut;  // invert the value on its way to the pin
    logic driveEn;    // pin driver enable
    logic presetLoad; // load HIGH at the next edge
  } cellStrobes_t;
endpackage

// File: rtl/olmc_ctrl.sv
`timescale 1ns/1ps
module olmc_ctrl
  import olmc_pkg::*;
(
  input  logic         cfgComb,
  input  logic         cfgActiveHigh,
  input  logic         enableTerm,
  input  logic         syncSet,
  output cellStrobes_t strobes
);
  always_comb begin
    strobes.useReg     = ~cfgComb;
    strobes.invertOut  = ~cfgActiveHigh;
    strobes.driveEn    = enableTerm;
    strobes.presetLoad = syncSet;
  end
endmodule

// File: rtl/olmc_dp.sv
`timescale 1ns/1ps
module olmc_dp
  import olmc_pkg::*;
(
  input  logic         clk,
  input  logic         asyncClear,
  input  logic         sumTerm,
  input  logic         padIn,
  input  cellStrobes_t strobes,
  output logic         padOut,
  output logic         padOe,
  output logic         feedback
);
  logic regQ;
  logic selVal;
  logic pinVal;

  always_ff @(posedge clk or posedge asyncClear) begin
    if (asyncClear)              regQ <= 1'b0;
    else if (strobes.presetLoad) regQ <= 1'b1;
    else                         regQ <= sumTerm;
  end

  always_comb begin
    selVal   = strobes.useReg ? regQ : sumTerm;
    pinVal   = selVal ^ strobes.invertOut;
    padOe    = strobes.driveEn;
    padOut   = strobes.driveEn ? pinVal : 1'b0;
    feedback = strobes.useReg ? regQ : padIn;
  end

  // R1: with no shared term in the previous cycle the register holds the last sum
  p_capture_r1: assert property (@(posedge clk) disable iff (asyncClear)
    (!$past(strobes.presetLoad) && !$past(asyncClear)) |-> (regQ == $past(sumTerm)));

  // R6: set seen at an edge leaves the register HIGH
  p_preset_r6: assert property (@(posedge clk) disable iff (asyncClear)
    ($past(strobes.presetLoad) && !$past(asyncClear)) |-> regQ);

  // R7: clear seen at an edge wins over set and leaves the register LOW
  p_clear_r7: assert property (@(posedge clk) disable iff (asyncClear)
    $past(asyncClear) |-> !regQ);

  // R4: a disabled driver carries no data
  p_quiet_r4: assert property (@(posedge clk) disable iff (asyncClear)
    !padOe |-> !padOut);
endmodule

// File: rtl/macro_cell_bank.sv
`timescale 1ns/1ps
module macro_cell_bank #(
  parameter int NUM_CELLS = 4
) (
  input  logic                 clk,
  input  logic                 asyncClear,
  input  logic                 syncSet,
  input  logic [NUM_CELLS-1:0] sumTerm,
  input  logic [NUM_CELLS-1:0] enableTerm,
  input  logic [NUM_CELLS-1:0] cfgComb,
  input  logic [NUM_CELLS-1:0] cfgActiveHigh,
  input  logic [NUM_CELLS-1:0] padIn,
  output logic [NUM_CELLS-1:0] padOut,
  output logic [NUM_CELLS-1:0] padOe,
  output logic [NUM_CELLS-1:0] feedback
);
  import olmc_pkg::*;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    cellStrobes_t cellStrobes;

    olmc_ctrl u_ctrl (
      .cfgComb       (cfgComb[i]),
      .cfgActiveHigh (cfgActiveHigh[i]),
      .enableTerm    (enableTerm[i]),
      .syncSet       (syncSet),
      .strobes       (cellStrobes)
    );

    olmc_dp u_dp (
      .clk        (clk),
      .asyncClear (asyncClear),
      .sumTerm    (sumTerm[i]),
      .padIn      (padIn[i]),
      .strobes    (cellStrobes),
      .padOut     (padOut[i]),
      .padOe      (padOe[i]),
      .feedback   (feedback[i])
    );
  end
endmodule

// File: tb/macro_cell_bank_tb.sv
`timescale 1ns/1ps
module macro_cell_bank_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         asyncClear, syncSet;
  logic [N-1:0] sumTerm, enableTerm, cfgComb, cfgActiveHigh, extDrive;
  logic [N-1:0] padIn;
  logic [N-1:0] padOut, padOe, feedback;
  logic [N-1:0] expQ;
  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  // pin model: driven level when enabled, external level otherwise
  assign padIn = (padOe & padOut) | (~padOe & extDrive);

  macro_cell_bank #(.NUM_CELLS(N)) u_dut (
    .clk(clk), .asyncClear(asyncClear), .syncSet(syncSet),
    .sumTerm(sumTerm), .enableTerm(enableTerm), .cfgComb(cfgComb),
    .cfgActiveHigh(cfgActiveHigh), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .feedback(feedback)
  );

  // reference register state (R1, R6, R7)
  always @(posedge clk or posedge asyncClear) begin
    if (asyncClear)   expQ <= '0;
    else if (syncSet) expQ <= '1;
    else              expQ <= sumTerm;
  end

  task automatic checkVec(string req, string what, logic [N-1:0] got, logic [N-1:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [N-1:0] eOut, eFb;
    for (int i = 0; i < N; i++) begin
      logic v;
      v = cfgComb[i] ? sumTerm[i] : expQ[i];
      v = cfgActiveHigh[i] ? v : ~v;
      eOut[i] = enableTerm[i] ? v : 1'b0;
      eFb[i]  = cfgComb[i] ? (enableTerm[i] ? eOut[i] : extDrive[i]) : expQ[i];
    end
    checkVec({tag, " R1 R2 R3 R8"}, "padOut", padOut, eOut);
    checkVec({tag, " R4"}, "padOe", padOe, enableTerm);
    checkVec({tag, " R5 R9"}, "feedback", feedback, eFb);
  endtask

  task automatic tick(string tag);
    @(posedge clk); #1;
    checkAll(tag);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    asyncClear = 0; syncSet = 0; sumTerm = '0; enableTerm = '0;
    cfgComb = '0; cfgActiveHigh = '1; extDrive = '0;
    #0.5 asyncClear = 1;
    @(negedge clk);
    enableTerm = '1;
    #0.5 checkAll("reset R7");
    @(negedge clk);
    asyncClear = 0;

    // registered, true polarity
    sumTerm = 4'b1010;
    #0.5 checkAll("R1 before edge");
    tick("R1 capture");
    sumTerm = 4'b0110;
    tick("R1 capture2");

    // mixed modes, polarity, enables and external levels
    cfgComb = 4'b0101; cfgActiveHigh = 4'b0011;
    enableTerm = 4'b0110; extDrive = 4'b1001; sumTerm = 4'b1100;
    #0.5 checkAll("R2 R3 R9 mixed");
    tick("R3 mixed edge");
    sumTerm = 4'b0011;
    #0.5 checkAll("R2 same cycle");
    tick("R5 mixed");

    // preset at an edge; pass-through cells keep following the sum
    syncSet = 1; sumTerm = 4'b0000;
    tick("R6 preset R8");
    syncSet = 0;
    tick("R6 release");

    // clear in the middle of a cycle, then held with preset across an edge
    sumTerm = 4'b1111; enableTerm = 4'b1111;
    tick("R1 before clear");
    @(posedge clk); #1;
    asyncClear = 1;
    #0.5 checkAll("R7 mid-cycle");
    syncSet = 1;
    tick("R7 priority");
    asyncClear = 0; syncSet = 0;
    #0.5 checkAll("R7 held");
    tick("R1 after clear");

    // input-only pass-through cells
    cfgComb = '1; enableTerm = '0; extDrive = 4'b0110;
    #0.5 checkAll("R9 input only");
    extDrive = 4'b1001;
    #0.5 checkAll("R9 input only2");

    // seeded random mix
    for (int k = 0; k < 400; k++) begin
      if (k % 16 == 0) begin
        cfgComb = N'($urandom); cfgActiveHigh = N'($urandom);
      end
      sumTerm = N'($urandom); enableTerm = N'($urandom); extDrive = N'($urandom);
      syncSet = ($urandom % 4) == 0;
      if (asyncClear) asyncClear = 0;
      else if (($urandom % 12) == 0) asyncClear = 1;
      #0.5 checkAll("R2 R4 R9 random");
      tick("R1 R6 R7 random");
    end
    asyncClear = 0; syncSet = 0;
    tick("final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule